// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave that holds seventeen 8-bit configuration bytes for a clock-generation subsystem. Both bus lines are sampled by a fast system clock, which must run well above the bus bit rate. The slave only ever pulls SDA low, through an output enable. It never stretches the clock, so the SCL enable stays low. Every configuration byte is available at all times on one flat parallel output.

A host writes with the write address. It then sends a command byte and a count byte, which the slave acknowledges and then throws away. The data bytes that follow land in register 0, register 1 and so on upward. The transfer may stop after any complete byte. Two register pairs take effect only when both of their bytes arrive in the same transfer.

A read returns the programmed byte count first, then the registers from 0 upward. One register sets how many bytes are returned.

A one-cycle service strobe tells a neighbouring watchdog that the host has written configuration data.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges address byte D2h (write) and D3h (read). For any other address it never drives SDA, and it ignores the bus until the next START.
- R2: In a write, the first two bytes after the address (command, then count) are acknowledged and change no register.
- R3: Data bytes of a write are acknowledged and stored to register 0, 1, 2 and upward in arrival order. A STOP after any complete byte keeps every byte already stored.
- R4: Registers 11 and 12 are updated together, and only when both arrive in one transfer. Registers 13 and 14 follow the same rule. A pair whose first byte arrived but whose second did not, because a STOP or a repeated START came first, leaves both registers unchanged.
- R5: Register 8 is the readback byte count. A write of 00h to it is ignored and the old value is kept, so the register never holds zero.
- R6: Registers 5, 6 and 7 are identification bytes. Writes to them are acknowledged but leave their values unchanged.
- R7: A read returns register 8 first and then registers 0, 1 and upward. Once as many register bytes have been returned as register 8 specifies, further bytes read as FFh.
- R8: When the master answers a read byte with NACK, the slave releases SDA and does not drive it again until a START.
- R9: After reset the registers hold these values: 0: 00h; 1 to 3: FFh; 4: 10h; 5: 91h; 6: 06h; 7: 0Ch; 8: 08h; 9 to 13: 00h; 14: 20h; 15: 08h; 16: 20h. Both output enables are low after reset.
- R10: The SDA output enable changes only while the synchronised SCL is low. The SCL output enable is never asserted.
- R11: The service strobe pulses for exactly one cycle at a STOP that closes a write segment in which at least one data byte arrived after the most recent START. It does not pulse otherwise.
- R12: Data bytes beyond register 16 are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| scl_oe | output | 1 | Pull-down enable for SCL (always low) |
| sda_oe | output | 1 | Pull-down enable for SDA |
| cfg_q | output | 136 | All registers; byte n sits at bits 8n+7 down to 8n |
| wd_kick | output | 1 | One-cycle watchdog service strobe |

## Verification
The bench sweeps write lengths from zero data bytes up to one byte past the last register. This catches an off-by-one in the write pointer, which would shift every byte. It also catches a pointer that wraps past the end of the map and corrupts register 0.

Lengths that stop between the two bytes of a pair, and a repeated START in the same place, expose a design that commits the first byte of a pair on its own.

A read is run for every byte-count value from 1 to 17, with one extra byte each time. This finds readback that runs one byte long or one byte short, and a count byte returned in the wrong place.

A zero written to the count register, writes aimed at the identification bytes, and a byte clocked after a master NACK cover the cases where a faulty slave would corrupt the count, change a fixed identifier, or keep driving the bus.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_A,
      ST_WR,
      ST_ACK_W,
      ST_RD,
      ST_ACK_R,
      ST_WAIT
   } smb_state_e;

   // Reset value of each configuration byte (the count byte default is a parameter).
   function automatic logic [7:0] cfg_default(input int unsigned idx);
      logic [7:0] v;
      case (idx)
         1, 2, 3: v = 8'hFF;
         4:       v = 8'h10;
         5:       v = 8'h91;
         6:       v = 8'h06;
         7:       v = 8'h0C;
         14:      v = 8'h20;
         15:      v = 8'h08;
         16:      v = 8'h20;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/smb_line_front.sv
module smb_line_front #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (SYNC < 2) begin : g_bad_sync
      $error("smb_line_front: SYNC must be at least 2");
   end

   logic [SYNC-1:0] scl_ff;
   logic [SYNC-1:0] sda_ff;
   logic            scl_d;
   logic            sda_d;

   if (SYNC == 2) begin : g_sync2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
         end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
         end
      end
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
         end else begin
            scl_ff <= {scl_ff[SYNC-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC-2:0], sda_i};
         end
      end
   end

   assign scl_s = scl_ff[SYNC-1];
   assign sda_s = sda_ff[SYNC-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
   import smb_cfg_pkg::*;
#(
   parameter int          NREG    = 17,
   parameter int          CNT_IDX = 8,
   parameter logic [7:0]  CNT_DEF = 8'h08,
   parameter int          ID_LO   = 5,
   parameter int          ID_HI   = 7,
   parameter int          PAIR0   = 11,
   parameter int          PAIR1   = 13,
   parameter int          IDXW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDXW-1:0]   wr_idx,
   input  logic [7:0]        wr_data,
   input  logic              abort,
   output logic [NREG*8-1:0] cfg_q
);

   if (CNT_IDX >= NREG) begin : g_bad_cnt
      $error("smb_cfg_regs: count register outside the map");
   end
   if (PAIR0 + 1 >= NREG || PAIR1 + 1 >= NREG) begin : g_bad_pair
      $error("smb_cfg_regs: register pair outside the map");
   end
   if (PAIR0 + 1 >= PAIR1) begin : g_bad_order
      $error("smb_cfg_regs: register pairs overlap or are out of order");
   end
   if (ID_HI < ID_LO || ID_HI >= NREG) begin : g_bad_id
      $error("smb_cfg_regs: identification range invalid");
   end
   if (CNT_DEF == 8'h00) begin : g_bad_def
      $error("smb_cfg_regs: count default must be non-zero");
   end

   localparam int NPAIR = 2;

   logic [NPAIR-1:0] commit;
   logic [7:0]       stg_dat [NPAIR];
   logic [7:0]       q       [NREG];

   // Staging of the first byte of each atomic pair.
   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      localparam int PB = (p == 0) ? PAIR0 : PAIR1;
      logic       v;
      logic [7:0] d;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v <= 1'b0;
            d <= 8'h00;
         end else if (abort) begin
            v <= 1'b0;
         end else if (wr_en && wr_idx == IDXW'(PB)) begin
            v <= 1'b1;
            d <= wr_data;
         end else if (commit[p]) begin
            v <= 1'b0;
         end
      end

      assign commit[p]  = wr_en && !abort && v && (wr_idx == IDXW'(PB + 1));
      assign stg_dat[p] = d;
   end

   // One storage variant per byte, picked by its role in the map.
   for (genvar i = 0; i < NREG; i++) begin : g_byte
      localparam logic [7:0] DEF = (i == CNT_IDX) ? CNT_DEF : cfg_default(i);

      if (i >= ID_LO && i <= ID_HI) begin : g_ro
         assign q[i] = DEF;
      end else begin : g_rw
         logic [7:0] r;
         logic       ld;
         logic [7:0] nd;

         if (i == CNT_IDX) begin : g_cnt
            assign ld = wr_en && (wr_idx == IDXW'(i)) && (wr_data != 8'h00);
            assign nd = wr_data;
         end else if (i == PAIR0) begin : g_p0_lo
            assign ld = commit[0];
            assign nd = stg_dat[0];
         end else if (i == PAIR0 + 1) begin : g_p0_hi
            assign ld = commit[0];
            assign nd = wr_data;
         end else if (i == PAIR1) begin : g_p1_lo
            assign ld = commit[1];
            assign nd = stg_dat[1];
         end else if (i == PAIR1 + 1) begin : g_p1_hi
            assign ld = commit[1];
            assign nd = wr_data;
         end else begin : g_plain
            assign ld = wr_en && (wr_idx == IDXW'(i));
            assign nd = wr_data;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  r <= DEF;
            else if (ld) r <= nd;
         end

         assign q[i] = r;
      end

      assign cfg_q[i*8 +: 8] = q[i];
   end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
   import smb_cfg_pkg::*;
#(
   parameter int          NREG    = 17,
   parameter logic [6:0]  ADDR7   = 7'h69,
   parameter int          CNT_IDX = 8,
   parameter logic [7:0]  CNT_DEF = 8'h08,
   parameter int          ID_LO   = 5,
   parameter int          ID_HI   = 7,
   parameter int          PAIR0   = 11,
   parameter int          PAIR1   = 13,
   parameter int          SYNC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic [NREG*8-1:0] cfg_q,
   output logic              wd_kick
);

   localparam int IDXW = $clog2(NREG + 2);

   if (NREG < 2 || NREG > 250) begin : g_bad_nreg
      $error("smb_cfg_slave: NREG out of range");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   smb_line_front #(.SYNC(SYNC)) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_state_e      state;
   logic [3:0]      bitcnt;
   logic [7:0]      shreg;
   logic [7:0]      txreg;
   logic [1:0]      phase;
   logic [IDXW-1:0] widx;
   logic [IDXW-1:0] ridx;
   logic            rw;
   logic            mack;
   logic            got_data;
   logic            sda_oe_q;
   logic            kick_q;

   logic            reg_we;
   logic [IDXW-1:0] reg_widx;
   logic            reg_abort;

   assign reg_we    = (state == ST_WR) && scl_fall && (bitcnt == 4'd8) && (phase == 2'd2)
                      && !start_det && !stop_det;
   assign reg_widx  = widx;
   assign reg_abort = start_det | stop_det;

   smb_cfg_regs #(
      .NREG    (NREG),
      .CNT_IDX (CNT_IDX),
      .CNT_DEF (CNT_DEF),
      .ID_LO   (ID_LO),
      .ID_HI   (ID_HI),
      .PAIR0   (PAIR0),
      .PAIR1   (PAIR1),
      .IDXW    (IDXW)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we),
      .wr_idx  (reg_widx),
      .wr_data (shreg),
      .abort   (reg_abort),
      .cfg_q   (cfg_q)
   );

   // Byte to shift out for the current read slot.
   logic [7:0]      cnt_val;
   logic [7:0]      rd_byte;
   logic [IDXW-1:0] rk;

   assign cnt_val = cfg_q[CNT_IDX*8 +: 8];
   assign rk      = ridx - IDXW'(1);

   always_comb begin
      rd_byte = 8'hFF;
      if (ridx == '0) begin
         rd_byte = cnt_val;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (rk == IDXW'(i) && i < int'(cnt_val)) rd_byte = cfg_q[i*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         txreg    <= 8'hFF;
         phase    <= '0;
         widx     <= '0;
         ridx     <= '0;
         rw       <= 1'b0;
         mack     <= 1'b0;
         got_data <= 1'b0;
         sda_oe_q <= 1'b0;
         kick_q   <= 1'b0;
      end else begin
         kick_q <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            sda_oe_q <= 1'b0;
            got_data <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            sda_oe_q <= 1'b0;
            kick_q   <= got_data;
            got_data <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE, ST_WAIT: ;
               ST_ADDR: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (shreg[7:1] == ADDR7) begin
                        sda_oe_q <= 1'b1;
                        rw       <= shreg[0];
                        ridx     <= '0;
                        state    <= ST_ACK_A;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               ST_ACK_A: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        txreg    <= rd_byte;
                        sda_oe_q <= ~rd_byte[7];
                        ridx     <= ridx + IDXW'(1);
                        state    <= ST_RD;
                     end else begin
                        sda_oe_q <= 1'b0;
                        phase    <= '0;
                        widx     <= '0;
                        state    <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     sda_oe_q <= 1'b1;
                     state    <= ST_ACK_W;
                     if (phase != 2'd2) begin
                        phase <= phase + 2'd1;
                     end else begin
                        got_data <= 1'b1;
                        if (widx != IDXW'(NREG)) widx <= widx + IDXW'(1);
                     end
                  end
               end
               ST_ACK_W: begin
                  if (scl_fall) begin
                     sda_oe_q <= 1'b0;
                     bitcnt   <= '0;
                     state    <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_oe_q <= 1'b0;
                        state    <= ST_ACK_R;
                     end else begin
                        txreg    <= {txreg[6:0], 1'b1};
                        sda_oe_q <= ~txreg[6];
                     end
                  end
               end
               ST_ACK_R: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if (mack) begin
                        txreg    <= rd_byte;
                        sda_oe_q <= ~rd_byte[7];
                        if (ridx != IDXW'(NREG + 1)) ridx <= ridx + IDXW'(1);
                        state    <= ST_RD;
                     end else begin
                        sda_oe_q <= 1'b0;
                        state    <= ST_WAIT;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe  = sda_oe_q;
   assign scl_oe  = 1'b0;
   assign wd_kick = kick_q;

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker
   import smb_cfg_pkg::*;
#(
   parameter int NREG    = 17,
   parameter int CNT_IDX = 8,
   parameter int PAIR0   = 11,
   parameter int PAIR1   = 13,
   parameter int IDXW    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_oe,
   input logic              scl_s,
   input logic              wd_kick,
   input logic [NREG*8-1:0] cfg_q,
   input logic              wr_en,
   input logic [IDXW-1:0]   wr_idx,
   input smb_state_e        state
);

   // R10: data line enable moves only while the clock line is low
   p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

   // R5: count register never holds zero
   p_cnt_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[CNT_IDX*8 +: 8] != 8'h00);

   // R11: strobe lasts a single cycle
   p_kick_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wd_kick |=> !wd_kick);

   // R8: slave silent once it waits for STOP
   p_wait_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !sda_oe);

   // R4: first byte of each pair changes only on the write of its partner
   p_pair0_atomic_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[PAIR0*8 +: 8] != $past(cfg_q[PAIR0*8 +: 8]))
         |-> ($past(wr_en) && $past(wr_idx) == IDXW'(PAIR0 + 1)));

   p_pair1_atomic_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[PAIR1*8 +: 8] != $past(cfg_q[PAIR1*8 +: 8]))
         |-> ($past(wr_en) && $past(wr_idx) == IDXW'(PAIR1 + 1)));

endmodule

bind smb_cfg_slave smb_cfg_checker #(
   .NREG    (NREG),
   .CNT_IDX (CNT_IDX),
   .PAIR0   (PAIR0),
   .PAIR1   (PAIR1),
   .IDXW    (IDXW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sda_oe  (sda_oe),
   .scl_s   (scl_s),
   .wd_kick (wd_kick),
   .cfg_q   (cfg_q),
   .wr_en   (reg_we),
   .wr_idx  (reg_widx),
   .state   (state)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;

   localparam int NREG = 17;
   localparam int Q    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic scl_oe, sda_oe, wd_kick;
   logic [NREG*8-1:0] cfg_q;

   wire scl_line = scl_m & ~scl_oe;
   wire sda_line = sda_m & ~sda_oe;

   smb_cfg_slave u_smb_cfg_slave (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_line),
      .sda_i   (sda_line),
      .scl_oe  (scl_oe),
      .sda_oe  (sda_oe),
      .cfg_q   (cfg_q),
      .wd_kick (wd_kick)
   );

   int checks = 0;
   int errors = 0;
   int kicks = 0;
   int r10_bad = 0;
   logic prev_oe = 1'b0;
   logic [7:0] model [NREG];
   logic [7:0] wdat [32];
   bit done = 0;

   always @(posedge clk) if (rst_n && wd_kick) kicks++;

   // R10 monitor: enable changes only with SCL low; SCL never driven
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe !== prev_oe && scl_line) r10_bad++;
         if (scl_oe !== 1'b0) r10_bad++;
      end
      prev_oe = sda_oe;
   end

   function automatic logic [7:0] defb(input int i);
      case (i)
         1, 2, 3: return 8'hFF;
         4:       return 8'h10;
         5:       return 8'h91;
         6:       return 8'h06;
         7:       return 8'h0C;
         8:       return 8'h08;
         14:      return 8'h20;
         15:      return 8'h08;
         16:      return 8'h20;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmp_all(input string req);
      int bad = -1;
      for (int i = 0; i < NREG; i++)
         if (cfg_q[i*8 +: 8] !== model[i] && bad < 0) bad = i;
      checks++;
      if (bad >= 0) begin
         errors++;
         $display("FAIL %s reg %0d actual %0h expected %0h", req, bad, cfg_q[bad*8 +: 8], model[bad]);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq(); wq();
   endtask

   task automatic bit_w(input logic b);
      sda_m = b; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bit_r(output logic b);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b = sda_line; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) bit_w(d[i]);
      bit_r(x);
      ack = ~x;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] d);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         bit_r(x);
         d[i] = x;
      end
      bit_w(~mack);
   endtask

   // Write n data bytes from wdat; ends with STOP or leaves the bus for a repeated START.
   task automatic do_write(input int n, input bit rstart_end);
      logic a;
      bit all_ack = 1;
      bit pv0 = 0, pv1 = 0;
      logic [7:0] pd0 = 0, pd1 = 0;
      int k0 = kicks;
      bus_start();
      send_byte(8'hD2, a);
      check("R1 write address ack", a, 1);
      send_byte(8'h5A, a); if (!a) all_ack = 0;
      send_byte(8'h00, a); if (!a) all_ack = 0;
      check("R2 command/count ack", all_ack, 1);
      all_ack = 1;
      for (int k = 0; k < n; k++) begin
         send_byte(wdat[k], a);
         if (!a) all_ack = 0;
         if (k >= NREG) continue;
         if (k >= 5 && k <= 7) continue;
         if (k == 8 && wdat[k] == 8'h00) continue;
         if (k == 11) begin pv0 = 1; pd0 = wdat[k]; end
         else if (k == 13) begin pv1 = 1; pd1 = wdat[k]; end
         else if (k == 12) begin if (pv0) begin model[11] = pd0; model[12] = wdat[k]; pv0 = 0; end end
         else if (k == 14) begin if (pv1) begin model[13] = pd1; model[14] = wdat[k]; pv1 = 0; end end
         else model[k] = wdat[k];
      end
      check(n > NREG ? "R12 data ack past end" : "R3 data ack", all_ack, 1);
      if (!rstart_end) begin
         bus_stop();
         repeat (4) @(negedge clk);
         check("R11 service strobe count", kicks - k0, (n > 0) ? 1 : 0);
      end
   endtask

   task automatic do_read(input int nb);
      logic a;
      logic [7:0] d;
      logic [7:0] e;
      int drove = 0;
      bus_start();
      send_byte(8'hD3, a);
      check("R1 read address ack", a, 1);
      recv_byte(1'b1, d);
      check("R7 count byte first", d, model[8]);
      for (int j = 0; j < nb; j++) begin
         recv_byte(j != nb - 1, d);
         e = (j < int'(model[8]) && j < NREG) ? model[j] : 8'hFF;
         check($sformatf("R7 read byte %0d", j), d, e);
      end
      for (int i = 7; i >= 0; i--) begin
         bit_r(a);
         d[i] = a;
         if (sda_oe) drove++;
      end
      bit_w(1'b1);
      check("R8 released after NACK", {d, 24'(drove)}, {8'hFF, 24'd0});
      bus_stop();
   endtask

   task automatic finish_run();
      checks++;
      if (r10_bad != 0) begin
         errors++;
         $display("FAIL R10 enable events actual %0d expected 0", r10_bad);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic a;
      for (int i = 0; i < NREG; i++) model[i] = defb(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9: reset values
      cmp_all("R9 reset values");
      check("R9 enables low", {scl_oe, sda_oe}, 2'b00);

      // R1: foreign address is ignored
      bus_start();
      send_byte(8'hA0, a);
      check("R1 foreign address not acked", a, 0);
      for (int i = 0; i < 4; i++) send_byte(8'h00, a);
      check("R1 silent after foreign address", a, 0);
      bus_stop();
      cmp_all("R1 no change after foreign address");

      // R2: no data bytes, command/count discarded
      do_write(0, 0);
      cmp_all("R2 command and count discarded");

      // R3/R4/R6/R12: write length sweep
      for (int n = 1; n <= NREG + 1; n++) begin
         for (int k = 0; k < 32; k++) wdat[k] = 8'((n * 29 + k * 53 + 7) & 8'hFF);
         do_write(n, 0);
         cmp_all($sformatf("R3 write length %0d", n));
         if (n == 12 || n == 14)
            check($sformatf("R4 half pair length %0d", n), cfg_q[(n-1)*8 +: 8], model[n-1]);
         if (n == 8) check("R6 identification fixed", cfg_q[5*8 +: 24], {8'h0C, 8'h06, 8'h91});
      end

      // R4: repeated START after the first byte of a pair
      for (int k = 0; k < 32; k++) wdat[k] = 8'(k * 7 + 3);
      wdat[8] = 8'h05;
      do_write(12, 1);
      do_write(0, 0);
      check("R4 repeated start drops half pair", cfg_q[11*8 +: 8], model[11]);
      cmp_all("R4 state after repeated start");

      // R5: zero to count register ignored
      wdat[8] = 8'h00;
      do_write(9, 0);
      check("R5 zero count ignored", cfg_q[8*8 +: 8], 8'h05);

      // R7/R8: readback for every count value
      for (int c = 1; c <= NREG; c++) begin
         for (int k = 0; k < 32; k++) wdat[k] = 8'((c * 41 + k * 19 + 1) & 8'hFF);
         wdat[8] = 8'(c);
         do_write(9, 0);
         do_read(c + 1);
      end

      done = 1;
      finish_run();
   end

endmodule